// File: doc/BRIEF.md
# Per-Bit Sampler Offset Calibrator

This block finds a 4-bit offset trim for every receive sampler in one data lane group. The data line idles at mid-rail during calibration. The block steps a shared offset code upward and applies it to every sampler at once. At each step it raises a training mode with termination forced on and waits a programmable number of cycles so the analog path can settle. It then asks for a feedback snapshot through a request/valid handshake and drops the training mode for at least one cycle.

For every bit, two trackers record two codes: the latest code at which the sampler read 1, and the earliest code at which it read 0. The trim for that bit is the midpoint of these two codes. Two overrides handle bits that never switch. When the sweep ends, the block sends out one packed word with one trim nibble per data bit, a separate trim for the strobe lane, and a one-cycle done pulse. The strobe lane is calibrated only when the low-power mode input was set at start.

Top module: `samp_ofs_cal`

## Requirements
- R1: After an accepted start, the shared code takes the values 1, 2, ..., 15 in ascending order. The block issues exactly one feedback request per value, then returns to idle.
- R2: While busy, `sweep_word_o` carries the current code in every nibble. Nibble i is bits [4i+3:4i]. While idle it is zero. Bit i's trim in `result_word_o` sits in the same nibble position.
- R3: Each step has this sequence:
  - `train_mode_o` and `term_force_o` rise together and stay high for exactly WAIT_CYCLES cycles before the one-cycle `sample_req_o`.
  - They stay high until `fb_valid_i` is seen.
  - They are low for at least one cycle before the next step.
  - They are never high while idle.
- R4: For each bit, the tracker behaves as follows:
  - Feedback 1 on `fb_data_i[i]` stores the current code as that bit's last-one.
  - Feedback 0 stores the current code as first-zero only if no first-zero is stored yet.
  - Both trackers start at 0 on every start.
- R5: A bit's trim is (first-zero + last-one) / 2, rounded down and clamped to 0..15.
- R6: A bit whose first-zero was never stored (it read 1 at every code) gets trim 15.
- R7: A bit whose last-one was never stored (it read 0 at every code) gets trim 0. This override is applied after the R6 override.
- R8: If `lowpwr_i` is 1 when start is accepted, the strobe lane `fb_data_i[8]` is calibrated by R4 to R7 and its trim appears on `strobe_code_o`. If `lowpwr_i` is 0, `fb_data_i[8]` is ignored and `strobe_code_o` is 0. Changes of `lowpwr_i` during a sweep have no effect.
- R9: `done_o` pulses for one cycle in the first idle cycle after the sweep. `result_word_o` and `strobe_code_o` are valid from that cycle and hold until the next done.
- R10: `start_i` is ignored while a sweep is in progress.
- R11: After reset, all outputs are zero and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only while idle |
| lowpwr_i | input | 1 | Include the strobe lane; sampled at start |
| fb_valid_i | input | 1 | Feedback response valid |
| fb_data_i | input | 9 | Sampler outputs; bits 0-7 data, bit 8 strobe |
| busy_o | output | 1 | Sweep in progress |
| train_mode_o | output | 1 | Sampler training mode enable |
| term_force_o | output | 1 | Termination forced on during training |
| sample_req_o | output | 1 | One-cycle feedback request |
| sweep_word_o | output | 32 | Shared code replicated in all nibbles |
| done_o | output | 1 | One-cycle completion pulse |
| result_word_o | output | 32 | Calibrated trims, one nibble per data bit |
| strobe_code_o | output | 4 | Calibrated trim of the strobe lane |

## Verification
The assertions check the following on every cycle:
- the code stays in range and moves by at most one;
- the nibbles of the sweep word agree;
- the handshake is shaped correctly (request only inside training mode, one-cycle request, nothing while idle);
- the done pulse lasts one cycle;
- a start during a sweep does not cut the sweep short.

The bench scenarios cover what a property cannot express without copying the logic:
- the exact settle count;
- the arithmetic of the midpoint trims;
- the two saturation overrides;
- strobe-lane gating by the latched low-power mode;
- results that hold between sweeps.

// File: rtl/samp_cal_pkg.sv
// Package: shared widths and the sequencer state type for the sampler
// offset calibrator. Assumes a 4-bit trim code swept over 1..15.
package samp_cal_pkg;
    localparam int CODE_W    = 4;
    localparam int DATA_BITS = 8;
    localparam int LANES     = DATA_BITS + 1;
    localparam int WORD_W    = DATA_BITS * CODE_W;
    localparam logic [CODE_W-1:0] CODE_FIRST = 4'd1;
    localparam logic [CODE_W-1:0] CODE_LAST  = 4'd15;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_REQ,
        ST_WAIT,
        ST_CLEAR
    } seq_state_e;
endpackage

// File: rtl/samp_cal_seq.sv
// Sweep sequencer. Steps the shared code 1..15. For each step it holds
// training mode for WAIT_CYCLES cycles, issues one feedback request,
// waits for the response, then drops training mode for one cycle.
// Assumes WAIT_CYCLES >= 1 and that every request is eventually answered.
module samp_cal_seq
    import samp_cal_pkg::*;
#(
    parameter int WAIT_CYCLES = 100
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  fb_valid_i,
    output logic  busy_o,
    output logic  train_mode_o,
    output logic  sample_req_o,
    output logic  capture_o,
    output logic  clear_o,
    output logic  finish_o,
    output code_t code_o
);
    localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WAIT_CYCLES - 1);

    seq_state_e       state_q;
    code_t            code_q;
    logic [CNT_W-1:0] cnt_q;

    // State, code and settle counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_SETTLE;
                        code_q  <= CODE_FIRST;
                        cnt_q   <= '0;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q == CNT_END) begin
                        state_q <= ST_REQ;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_REQ: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (fb_valid_i) begin
                        state_q <= ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    if (code_q == CODE_LAST) begin
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_SETTLE;
                        code_q  <= code_q + 1'b1;
                        cnt_q   <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decoded controls for the handshake and the trackers.
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        train_mode_o = (state_q == ST_SETTLE) || (state_q == ST_REQ) || (state_q == ST_WAIT);
        sample_req_o = (state_q == ST_REQ);
        capture_o    = (state_q == ST_WAIT) && fb_valid_i;
        clear_o      = (state_q == ST_IDLE) && start_i;
        finish_o     = (state_q == ST_CLEAR) && (code_q == CODE_LAST);
        code_o       = code_q;
    end
endmodule

// File: rtl/samp_cal_track.sv
// Per-bit tracker. Stores the latest code at which the sampler read 1
// and the earliest code at which it read 0. A stored value of 0 means
// "never seen", which relies on the sweep never using code 0.
module samp_cal_track
    import samp_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear_i,
    input  logic  capture_i,
    input  logic  enable_i,
    input  code_t code_i,
    input  logic  fb_i,
    output code_t first_zero_o,
    output code_t last_one_o
);
    code_t first_zero_q;
    code_t last_one_q;

    // Tracker update on each captured feedback sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            first_zero_q <= '0;
            last_one_q   <= '0;
        end else if (capture_i && enable_i) begin
            if (fb_i) begin
                last_one_q <= code_i;
            end else if (first_zero_q == '0) begin
                first_zero_q <= code_i;
            end
        end
    end

    assign first_zero_o = first_zero_q;
    assign last_one_o   = last_one_q;
endmodule

// File: rtl/samp_cal_resolve.sv
// Trim resolver, purely combinational. Takes the midpoint of the two
// tracked codes and clamps it. If a bit never read 0 its trim goes to
// full scale. If it never read 1 its trim goes to zero; this override
// is applied last.
module samp_cal_resolve
    import samp_cal_pkg::*;
(
    input  code_t first_zero_i,
    input  code_t last_one_i,
    output code_t trim_o
);
    logic [CODE_W:0] sum;
    logic [CODE_W:0] half;

    // Midpoint, clamp and saturation overrides.
    always_comb begin
        sum  = {1'b0, first_zero_i} + {1'b0, last_one_i};
        half = sum >> 1;
        if (half > {1'b0, CODE_LAST}) begin
            trim_o = CODE_LAST;
        end else begin
            trim_o = half[CODE_W-1:0];
        end
        if (first_zero_i == '0) begin
            trim_o = CODE_LAST;
        end
        if (last_one_i == '0) begin
            trim_o = '0;
        end
    end
endmodule

// File: rtl/samp_ofs_cal.sv
// Top of the per-bit sampler offset calibrator. Connects the sweep
// sequencer to one tracker and one resolver per lane (8 data bits plus
// the strobe lane). Latches the low-power mode at start, and registers
// the packed results together with the done pulse.
module samp_ofs_cal
    import samp_cal_pkg::*;
#(
    parameter int WAIT_CYCLES = 100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 lowpwr_i,
    input  logic                 fb_valid_i,
    input  logic [LANES-1:0]     fb_data_i,
    output logic                 busy_o,
    output logic                 train_mode_o,
    output logic                 term_force_o,
    output logic                 sample_req_o,
    output logic [WORD_W-1:0]    sweep_word_o,
    output logic                 done_o,
    output logic [WORD_W-1:0]    result_word_o,
    output logic [CODE_W-1:0]    strobe_code_o
);
    logic  busy;
    logic  train_mode;
    logic  capture;
    logic  clear;
    logic  finish;
    code_t code;
    logic  lp_q;
    logic  done_q;
    logic [WORD_W-1:0] result_q;
    code_t strobe_q;
    code_t first_zero [LANES];
    code_t last_one   [LANES];
    code_t trim       [LANES];
    logic [WORD_W-1:0] packed_trim;

    samp_cal_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .fb_valid_i   (fb_valid_i),
        .busy_o       (busy),
        .train_mode_o (train_mode),
        .sample_req_o (sample_req_o),
        .capture_o    (capture),
        .clear_o      (clear),
        .finish_o     (finish),
        .code_o       (code)
    );

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // The strobe lane takes part only in low-power mode.
            logic lane_en;
            if (g < DATA_BITS) begin : g_data
                assign lane_en = 1'b1;
                assign packed_trim[g*CODE_W +: CODE_W] = trim[g];
            end else begin : g_strobe
                assign lane_en = lp_q;
            end

            samp_cal_track u_track (
                .clk          (clk),
                .rst_n        (rst_n),
                .clear_i      (clear),
                .capture_i    (capture),
                .enable_i     (lane_en),
                .code_i       (code),
                .fb_i         (fb_data_i[g]),
                .first_zero_o (first_zero[g]),
                .last_one_o   (last_one[g])
            );

            samp_cal_resolve u_resolve (
                .first_zero_i (first_zero[g]),
                .last_one_i   (last_one[g]),
                .trim_o       (trim[g])
            );
        end
    endgenerate

    // Latch the low-power mode when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_q <= 1'b0;
        end else if (clear) begin
            lp_q <= lowpwr_i;
        end
    end

    // Register results and the done pulse at the end of the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
            strobe_q <= '0;
        end else begin
            done_q <= finish;
            if (finish) begin
                result_q <= packed_trim;
                strobe_q <= lp_q ? trim[DATA_BITS] : '0;
            end
        end
    end

    assign busy_o        = busy;
    assign train_mode_o  = train_mode;
    assign term_force_o  = train_mode;
    assign sweep_word_o  = busy ? {DATA_BITS{code}} : '0;
    assign done_o        = done_q;
    assign result_word_o = result_q;
    assign strobe_code_o = strobe_q;
endmodule

// File: rtl/samp_ofs_cal_chk.sv
// Checker for samp_ofs_cal. It observes only the ports and is attached
// with bind. It checks the sweep code range and step size, the shape of
// the handshake, the done pulse, and that a start during a sweep is ignored.
module samp_ofs_cal_chk
    import samp_cal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              train_mode_o,
    input logic              term_force_o,
    input logic              sample_req_o,
    input logic [WORD_W-1:0] sweep_word_o,
    input logic              done_o
);
    AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (sweep_word_o[CODE_W-1:0] != '0)); // R1
    AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |->
            (sweep_word_o[CODE_W-1:0] == $past(sweep_word_o[CODE_W-1:0]) ||
             sweep_word_o[CODE_W-1:0] == $past(sweep_word_o[CODE_W-1:0]) + 1'b1)); // R1
    AST_NIBBLES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_word_o[WORD_W-1:CODE_W] == sweep_word_o[WORD_W-CODE_W-1:0]); // R2
    AST_IDLE_WORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sweep_word_o == '0)); // R2
    AST_REQ_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req_o |-> (train_mode_o && term_force_o)); // R3
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req_o |=> !sample_req_o); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!train_mode_o && !term_force_o && !sample_req_o)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9
    AST_DONE_AFTER_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !done_o) |=> (busy_o || done_o)); // R10
endmodule

bind samp_ofs_cal samp_ofs_cal_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .train_mode_o (train_mode_o),
    .term_force_o (term_force_o),
    .sample_req_o (sample_req_o),
    .sweep_word_o (sweep_word_o),
    .done_o       (done_o)
);

// File: tb/samp_ofs_cal_bench.sv
// Scoreboard bench. The driver task computes the expected trims from the
// feedback patterns and pushes them into a queue. A responder answers
// feedback requests and checks each step. A monitor pops the queue on
// every done pulse and compares.
module samp_ofs_cal_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WAITC      = 4;
    localparam int NLANE      = 9;

    typedef struct packed {
        logic [31:0] word;
        logic [3:0]  strobe;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        lowpwr_i = 1'b0;
    logic        fb_valid_i = 1'b0;
    logic [8:0]  fb_data_i = '0;
    logic        busy_o, train_mode_o, term_force_o, sample_req_o, done_o;
    logic [31:0] sweep_word_o, result_word_o;
    logic [3:0]  strobe_code_o;

    int checks = 0;
    int failures = 0;
    int dones = 0;
    int steps = 0;
    int settle = 0;
    logic [3:0]  step_code = 4'd1;
    logic [14:0] pat [NLANE];
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    samp_ofs_cal #(.WAIT_CYCLES(WAITC)) u_samp_ofs_cal (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .lowpwr_i(lowpwr_i),
        .fb_valid_i(fb_valid_i), .fb_data_i(fb_data_i), .busy_o(busy_o),
        .train_mode_o(train_mode_o), .term_force_o(term_force_o),
        .sample_req_o(sample_req_o), .sweep_word_o(sweep_word_o), .done_o(done_o),
        .result_word_o(result_word_o), .strobe_code_o(strobe_code_o)
    );

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected trim of one lane from its 15-step pattern (bit c-1 = code c).
    function automatic logic [3:0] exp_trim(input logic [14:0] p);
        int fz = 0;
        int lo = 0;
        int r;
        for (int c = 1; c <= 15; c++) begin
            if (p[c-1]) lo = c;
            else if (fz == 0) fz = c;
        end
        r = (fz + lo) / 2;
        if (r > 15) r = 15;
        if (fz == 0) r = 15;
        if (lo == 0) r = 0;
        return 4'(r);
    endfunction

    // Responder: answers requests and checks code, word and settle length.
    initial begin
        forever begin
            @(negedge clk);
            if (train_mode_o && !sample_req_o) settle++;
            if (!train_mode_o) settle = 0;
            if (sample_req_o) begin
                check(sweep_word_o[3:0] == step_code, "R1 code", 36'(sweep_word_o[3:0]), 36'(step_code));
                check(sweep_word_o == {8{step_code}}, "R2 word", 36'(sweep_word_o), 36'({8{step_code}}));
                check(settle == WAITC && term_force_o, "R3 settle", 36'(settle), 36'(WAITC));
                @(negedge clk);
                fb_valid_i = 1'b1;
                for (int b = 0; b < NLANE; b++) fb_data_i[b] = pat[b][step_code-1];
                @(negedge clk);
                fb_valid_i = 1'b0;
                fb_data_i = '0;
                check(!train_mode_o, "R3 gap", 36'(train_mode_o), 36'(0));
                settle = 0;
                steps++;
                step_code = step_code + 1'b1;
            end
        end
    end

    // Monitor: compares results on each done pulse against the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (done_o) begin
                exp_t e;
                dones++;
                check(q.size() > 0, "R9 unexpected done", 36'(q.size()), 36'(1));
                if (q.size() > 0) begin
                    e = q.pop_front();
                    check(result_word_o == e.word, "R5 R6 R7 word", 36'(result_word_o), 36'(e.word));
                    check(strobe_code_o == e.strobe, "R8 strobe", 36'(strobe_code_o), 36'(e.strobe));
                end
                check(!busy_o, "R9 idle at done", 36'(busy_o), 36'(0));
            end
        end
    end

    // Driver: computes the expectation, runs one sweep and optionally
    // disturbs it with start pulses and mode flips.
    task automatic run_case(input bit lp, input bit disturb, input logic [31:0] prev);
        exp_t e;
        int d0;
        for (int b = 0; b < 8; b++) e.word[b*4 +: 4] = exp_trim(pat[b]);
        e.strobe = lp ? exp_trim(pat[8]) : 4'd0;
        q.push_back(e);
        check(result_word_o == prev, "R9 hold", 36'(result_word_o), 36'(prev));
        steps = 0;
        step_code = 4'd1;
        d0 = dones;
        @(negedge clk);
        lowpwr_i = lp;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin
            for (int k = 0; k < 3; k++) begin
                repeat (20) @(negedge clk);
                check(busy_o, "R10 busy", 36'(busy_o), 36'(1));
                start_i = 1'b1;
                lowpwr_i = ~lowpwr_i;
                @(negedge clk);
                start_i = 1'b0;
            end
        end
        while (dones == d0) @(negedge clk);
        check(steps == 15, "R1 steps", 36'(steps), 36'(15));
        repeat (3) @(negedge clk);
        check(dones == d0 + 1, "R10 single done", 36'(dones), 36'(d0 + 1));
        check(!busy_o, "R1 idle", 36'(busy_o), 36'(0));
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check({busy_o, train_mode_o, term_force_o, sample_req_o, done_o} == 5'b0, "R11 ctrl", 36'({busy_o, train_mode_o, sample_req_o, done_o}), 36'(0));
        check(result_word_o == 0 && strobe_code_o == 0 && sweep_word_o == 0, "R11 data", 36'(result_word_o), 36'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Clean thresholds, strobe lane ignored (R4, R5, R8).
        for (int b = 0; b < 8; b++) pat[b] = 15'((1 << (3 + b)) - 1);
        pat[8] = 15'h5A5A;
        run_case(1'b0, 1'b0, 32'h0);

        // Saturation, noise and strobe lane (R6, R7, R8).
        pat[0] = 15'h7FFF; pat[1] = 15'h0000; pat[2] = 15'h5555; pat[3] = 15'h4000;
        pat[4] = 15'h3FFF; pat[5] = 15'h0001; pat[6] = 15'h0F0F; pat[7] = 15'h00F0;
        pat[8] = 15'h01FF;
        run_case(1'b1, 1'b0, 32'h76543210 + 32'h33333333);

        // Start pulses and mode flips during a sweep (R10, R8 latched).
        for (int b = 0; b < 8; b++) pat[b] = 15'((1 << (12 - b)) - 1);
        pat[8] = 15'h0007;
        begin
            logic [31:0] pw;
            pw = {exp_trim(15'h00F0), exp_trim(15'h0F0F), exp_trim(15'h0001), exp_trim(15'h3FFF),
                  exp_trim(15'h4000), exp_trim(15'h5555), exp_trim(15'h0000), exp_trim(15'h7FFF)};
            run_case(1'b1, 1'b1, pw);
            // Strobe lane all ones while low-power mode is off (R8).
            for (int b = 0; b < 8; b++) pw[b*4 +: 4] = exp_trim(15'((1 << (12 - b)) - 1));
            for (int b = 0; b < 8; b++) pat[b] = 15'h7FFE >> b;
            pat[8] = 15'h7FFF;
            run_case(1'b0, 1'b0, pw);
        end
        check(q.size() == 0, "R9 queue drained", 36'(q.size()), 36'(0));
        summary();
    end
endmodule